// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Interlock

This block decides where each of the two ALU operands of the instruction now in the execute stage comes from. An operand can come from the register file read, from the ALU result held in the execute/memory latch, or from the value held in the memory/writeback latch. Register-specifier comparators drive each select. A producer that has not yet reached writeback is the only kind that can hand a value forward early. A producer three instructions ahead needs no path, because the register file writes in the first half of the cycle and reads in the second.

The block also watches for a load in the execute stage whose destination is a source of the instruction being decoded. In that cycle it raises three strobes together. The pipeline holds the program counter, holds the fetch/decode latch, and zeroes the control bits entering the decode/execute latch. The cycle after the bubble, the load sits in the memory/writeback latch and the normal bypass hands its data to the consumer. All outputs are combinational from the specifier inputs. The clock and reset serve only the embedded property checks.

Top module: `bypass_unit`

## Requirements
- R1: When the execute/memory producer writes (write enable 1), has a nonzero destination, and that destination equals an operand's source specifier, the operand select is 2'b10.
- R2: When only the memory/writeback producer qualifies this way for an operand, the select is 2'b01. This is also the path that delivers load data to the consumer after the stall cycle.
- R3: When both producers qualify for the same operand, the execute/memory producer is chosen (2'b10).
- R4: A producer whose write enable is 0 never causes forwarding, even when its destination matches.
- R5: A destination of register 0 never causes forwarding, even with write enable 1 and a matching source.
- R6: With no qualifying producer, the select is 2'b00 (register file). A select of 2'b11 never appears.
- R7: When the execute-stage instruction is a load with a nonzero destination equal to either decode-stage source, `pcHold`, `ifidHold` and `idexBubble` are all 1 in that same cycle.
- R8: No stall strobe is raised when the execute-stage instruction is not a load, when the load's destination is 0, or when it matches neither decode-stage source.
- R9: The two operand selects are computed independently. Each follows R1 to R6 using only its own source specifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset, gates the property checks |
| exSrcA | input | AW | Source specifier of operand A, instruction in execute |
| exSrcB | input | AW | Source specifier of operand B, instruction in execute |
| exmemDst | input | AW | Destination specifier in the execute/memory latch |
| exmemWen | input | 1 | Register write enable in the execute/memory latch |
| memwbDst | input | AW | Destination specifier in the memory/writeback latch |
| memwbWen | input | 1 | Register write enable in the memory/writeback latch |
| idSrcA | input | AW | First source specifier of the instruction in decode |
| idSrcB | input | AW | Second source specifier of the instruction in decode |
| idexDst | input | AW | Destination specifier of the instruction in execute |
| idexLoad | input | 1 | Instruction in execute reads data memory |
| fwdSelA | output | 2 | Operand A source: 00 register file, 10 exec/mem, 01 mem/wb |
| fwdSelB | output | 2 | Operand B source, same encoding |
| pcHold | output | 1 | Keep the program counter unchanged this cycle |
| ifidHold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| idexBubble | output | 1 | Zero the control bits entering the decode/execute latch |

## Verification
The bench builds the block with a 4-bit register specifier, so there are sixteen registers. The top index 15 and the zero index can then be exercised as real boundary cases without a wide table. It covers the case where both producers match, with and without write enables, register 0 against enabled producers, and operands that pick different sources in the same cycle. A three-step sequence then follows one load through its stall cycle, the bubble cycle and the memory/writeback bypass that finally feeds its consumer.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwdSrc_t;

  typedef struct packed {
    logic pcHold;
    logic ifidHold;
    logic bubble;
  } stallStrobes_t;

endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] srcReg,
  input  logic [AW-1:0] dstReg,
  input  logic          wen,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wen && (dstReg != ZERO_REG) && (dstReg == srcReg);
  end
endmodule

// File: rtl/bypass_datapath.sv
module bypass_datapath
  import bypass_pkg::*;
#(
  parameter int AW      = 5,
  parameter int NUM_OPS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_OPS-1:0][AW-1:0]   opSrc,
  input  logic [AW-1:0]                exmemDst,
  input  logic                         exmemWen,
  input  logic [AW-1:0]                memwbDst,
  input  logic                         memwbWen,
  output logic [NUM_OPS-1:0][1:0]      fwdSel
);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic memHit;
    logic wbHit;

    bypass_match #(.AW(AW)) u_memCmp (
      .srcReg(opSrc[g]), .dstReg(exmemDst), .wen(exmemWen), .hit(memHit)
    );
    bypass_match #(.AW(AW)) u_wbCmp (
      .srcReg(opSrc[g]), .dstReg(memwbDst), .wen(memwbWen), .hit(wbHit)
    );

    // younger producer has priority
    always_comb begin
      if (memHit)     fwdSel[g] = SRC_MEM;
      else if (wbHit) fwdSel[g] = SRC_WB;
      else            fwdSel[g] = SRC_RF;
    end

    // R1/R3: enabled nonzero exec/mem match always wins
    p_mem_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (exmemWen && exmemDst != '0 && exmemDst == opSrc[g]) |-> fwdSel[g] == SRC_MEM);

    // R2: mem/wb only selected when exec/mem cannot supply the operand
    p_wb_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwdSel[g] == SRC_WB) |-> (memwbWen && memwbDst == opSrc[g] &&
        !(exmemWen && exmemDst == opSrc[g])));

    // R4: disabled writers never forward
    p_wen_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!exmemWen && !memwbWen) |-> fwdSel[g] == SRC_RF);

    // R5: register 0 never forwards
    p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (opSrc[g] == '0) |-> fwdSel[g] == SRC_RF);

    // R6: no illegal select code
    p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwdSel[g]));
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idSrcA,
  input  logic [AW-1:0] idSrcB,
  input  logic [AW-1:0] idexDst,
  input  logic          idexLoad,
  output stallStrobes_t strobes
);
  logic hitA;
  logic hitB;
  logic loadUse;

  bypass_match #(.AW(AW)) u_cmpA (
    .srcReg(idSrcA), .dstReg(idexDst), .wen(idexLoad), .hit(hitA)
  );
  bypass_match #(.AW(AW)) u_cmpB (
    .srcReg(idSrcB), .dstReg(idexDst), .wen(idexLoad), .hit(hitB)
  );

  always_comb begin
    loadUse          = hitA || hitB;
    strobes.pcHold   = loadUse;
    strobes.ifidHold = loadUse;
    strobes.bubble   = loadUse;
  end

  // R7: the three strobes move together
  p_stall_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pcHold |-> (strobes.ifidHold && strobes.bubble));

  // R7: matching load always stalls
  p_load_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idexLoad && idexDst != '0 && (idexDst == idSrcA || idexDst == idSrcB))
      |-> strobes.pcHold);

  // R8: no stall without a load
  p_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idexLoad |-> !strobes.pcHold);

  // R8: a load to register 0 never stalls
  p_zero_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idexDst == '0) |-> !strobes.bubble);

endmodule

// File: rtl/bypass_unit.sv
module bypass_unit
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] exSrcA,
  input  logic [AW-1:0] exSrcB,
  input  logic [AW-1:0] exmemDst,
  input  logic          exmemWen,
  input  logic [AW-1:0] memwbDst,
  input  logic          memwbWen,
  input  logic [AW-1:0] idSrcA,
  input  logic [AW-1:0] idSrcB,
  input  logic [AW-1:0] idexDst,
  input  logic          idexLoad,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          pcHold,
  output logic          ifidHold,
  output logic          idexBubble
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][AW-1:0] opSrc;
  logic [NUM_OPS-1:0][1:0]    opSel;
  stallStrobes_t              strobes;

  assign opSrc[0] = exSrcA;
  assign opSrc[1] = exSrcB;

  bypass_datapath #(.AW(AW), .NUM_OPS(NUM_OPS)) u_datapath (
    .clk(clk), .rst_n(rst_n), .opSrc(opSrc),
    .exmemDst(exmemDst), .exmemWen(exmemWen),
    .memwbDst(memwbDst), .memwbWen(memwbWen),
    .fwdSel(opSel)
  );

  hazard_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .idSrcA(idSrcA), .idSrcB(idSrcB),
    .idexDst(idexDst), .idexLoad(idexLoad), .strobes(strobes)
  );

  assign fwdSelA    = opSel[0];
  assign fwdSelB    = opSel[1];
  assign pcHold     = strobes.pcHold;
  assign ifidHold   = strobes.ifidHold;
  assign idexBubble = strobes.bubble;

endmodule

// File: tb/bypass_unit_test.sv
`timescale 1ns/1ps
module bypass_unit_test;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] exSrcA, exSrcB, exmemDst, memwbDst, idSrcA, idSrcB, idexDst;
  logic exmemWen, memwbWen, idexLoad;
  logic [1:0] fwdSelA, fwdSelB;
  logic pcHold, ifidHold, idexBubble;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       st;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  bypass_unit #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .exSrcA(exSrcA), .exSrcB(exSrcB),
    .exmemDst(exmemDst), .exmemWen(exmemWen), .memwbDst(memwbDst),
    .memwbWen(memwbWen), .idSrcA(idSrcA), .idSrcB(idSrcB),
    .idexDst(idexDst), .idexLoad(idexLoad), .fwdSelA(fwdSelA),
    .fwdSelB(fwdSelB), .pcHold(pcHold), .ifidHold(ifidHold),
    .idexBubble(idexBubble)
  );

  task automatic compare(input expItem_t e);
    testsRun++;
    if (fwdSelA !== e.a || fwdSelB !== e.b || pcHold !== e.st ||
        ifidHold !== e.st || idexBubble !== e.st) begin
      testsFailed++;
      $display("FAIL %s: got A=%b B=%b hold=%b/%b/%b, expected A=%b B=%b stall=%b",
               e.tag, fwdSelA, fwdSelB, pcHold, ifidHold, idexBubble, e.a, e.b, e.st);
    end
  endtask

  task automatic drive(input int xA, input int xB, input int emD, input bit emW,
                       input int mwD, input bit mwW, input int iA, input int iB,
                       input int ixD, input bit ixL, input logic [1:0] eA,
                       input logic [1:0] eB, input logic eSt, input string tag);
    expItem_t e;
    @(posedge clk);
    #1;
    exSrcA = AW'(xA); exSrcB = AW'(xB);
    exmemDst = AW'(emD); exmemWen = emW;
    memwbDst = AW'(mwD); memwbWen = mwW;
    idSrcA = AW'(iA); idSrcB = AW'(iB);
    idexDst = AW'(ixD); idexLoad = ixL;
    e.a = eA; e.b = eB; e.st = eSt; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  initial begin
    expItem_t r;
    exSrcA = '0; exSrcB = '0; exmemDst = '0; memwbDst = '0;
    idSrcA = '0; idSrcB = '0; idexDst = '0;
    exmemWen = 1'b0; memwbWen = 1'b0; idexLoad = 1'b0;
    repeat (3) @(negedge clk);
    r.a = 2'b00; r.b = 2'b00; r.st = 1'b0; r.tag = "R6 reset state";
    compare(r);
    rst_n = 1'b1;

    // xA xB emD emW mwD mwW iA iB ixD ixL  expA  expB  stall
    drive(3, 4, 3, 0, 4, 0, 1, 2, 0, 0, 2'b00, 2'b00, 0, "R4 disabled writers");
    drive(3, 5, 3, 1, 0, 0, 1, 2, 0, 0, 2'b10, 2'b00, 0, "R1 exec/mem to A");
    drive(1, 7, 7, 1, 0, 0, 1, 2, 0, 0, 2'b00, 2'b10, 0, "R1 exec/mem to B");
    drive(6, 1, 2, 1, 6, 1, 1, 2, 0, 0, 2'b01, 2'b00, 0, "R2 mem/wb to A");
    drive(9, 9, 9, 1, 9, 1, 1, 2, 0, 0, 2'b10, 2'b10, 0, "R3 younger wins");
    drive(9, 9, 9, 0, 9, 1, 1, 2, 0, 0, 2'b01, 2'b01, 0, "R4 older used when younger disabled");
    drive(0, 0, 0, 1, 0, 1, 1, 2, 0, 0, 2'b00, 2'b00, 0, "R5 register zero");
    drive(2, 5, 2, 1, 5, 1, 1, 2, 0, 0, 2'b10, 2'b01, 0, "R9 mixed sources");
    drive(15, 14, 14, 1, 15, 1, 1, 2, 0, 0, 2'b01, 2'b10, 0, "R9 top index");
    drive(1, 2, 3, 1, 4, 1, 1, 2, 0, 0, 2'b00, 2'b00, 0, "R6 no match");
    drive(1, 2, 0, 0, 0, 0, 8, 3, 8, 1, 2'b00, 2'b00, 1, "R7 load feeds A");
    drive(1, 2, 0, 0, 0, 0, 3, 11, 11, 1, 2'b00, 2'b00, 1, "R7 load feeds B");
    drive(1, 2, 0, 0, 0, 0, 8, 3, 8, 0, 2'b00, 2'b00, 0, "R8 non-load producer");
    drive(1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, "R8 load to register zero");
    drive(1, 2, 0, 0, 0, 0, 5, 6, 4, 1, 2'b00, 2'b00, 0, "R8 load no match");
    // load r8 followed by consumer of r8: stall, bubble, then mem/wb bypass
    drive(1, 2, 0, 0, 0, 0, 8, 9, 8, 1, 2'b00, 2'b00, 1, "R7 sequence stall");
    drive(1, 2, 8, 1, 0, 0, 8, 9, 0, 0, 2'b00, 2'b00, 0, "R8 sequence bubble");
    drive(8, 9, 0, 0, 8, 1, 1, 2, 0, 0, 2'b01, 2'b00, 0, "R2 sequence load data");

    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule